// File: doc/BRIEF.md
# Chainable Column-Driver Pixel Capture

This block gathers one line of display data for a column driver that sits in a chain of identical drivers. A 12-bit data bus is sampled on both edges of the shift clock: the word present at the rising edge and the word present at the following falling edge together make one 24-bit pixel of three 8-bit gray levels. A start pulse arms the capture. The block then fills a data register of 160 pixels (480 dots) in a direction chosen by a static control. When its share of the line is full, it hands a start pulse to the next driver.

A synchronous strobe moves the whole data register into an output latch in one step. The capture of the next line can then proceed while the latched line is being displayed. An optional inversion control flips every data bit as it is stored.

The double-rate input is modelled as single-ended logic. The rising-edge word and the falling-edge word are held in separate registers, and the pixel is written at the following rising edge.

Top module: `cascade_pixel_capture`

## Requirements
- R1: A pixel is the 24-bit word {rising-edge bus word, falling-edge bus word}. Dot 0 of the pixel is bits 23:16, dot 1 is bits 15:8 and dot 2 is bits 7:0. The latch port carries dot k in bits [8k+7:8k].
- R2: A start pulse sampled high at a rising clock edge makes the data of that same clock pixel 0. The next clocks carry pixels 1, 2, and so on.
- R3: With `fill_up_i` high, `start_right_i` is the start input, the cascade pulse leaves on `start_left_o`, `start_right_o` stays low, and pixel i dot d is stored at dot 3i+d. With `fill_up_i` low, the two start pins swap roles and the same dot is stored at 479-(3i+d). A pulse on the start input that is not selected has no effect.
- R4: After 160 pixels the capture stops. Data on later clocks leaves the data register unchanged until a new start pulse arrives.
- R5: The selected cascade output goes high at the falling edge of the 160th clock, counting the start clock as the first. It stays high for exactly one clock period.
- R6: A strobe seen high at a rising edge after being low at the previous edge copies the data register into the latch. `lat_valid_o` is then high for that one clock. A strobe held high makes no further copies, and the latch does not change at any other time.
- R7: With `invert_i` high, every bit of each dot is inverted before it is stored. With `invert_i` low, data is stored unchanged.
- R8: A start pulse that arrives during a capture restarts the capture at pixel 0. Pixels stored before the restart remain in the data register.
- R9: The pixel of clock j is stored at the rising edge that begins clock j+1. A strobe edge at that same rising edge latches the register contents as they were before this write.
- R10: During reset the data register and the latch are zero, `lat_valid_o` and both start outputs are low, and no capture is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock; data is sampled on both edges |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| fill_up_i | input | 1 | Static fill direction: 1 = fill toward dot 479, 0 = fill toward dot 0 |
| invert_i | input | 1 | Static control: invert data bits as they are stored |
| start_right_i | input | 1 | Start pulse input when `fill_up_i` = 1 |
| start_left_i | input | 1 | Start pulse input when `fill_up_i` = 0 |
| start_right_o | output | 1 | Cascade start pulse out when `fill_up_i` = 0 |
| start_left_o | output | 1 | Cascade start pulse out when `fill_up_i` = 1 |
| pix_bus_i | input | 12 | Half-pixel data, one word per clock edge |
| strobe_i | input | 1 | Line strobe; its rising edge loads the latch |
| lat_data_o | output | 3840 | Latched line, 480 dots of 8 bits |
| lat_valid_o | output | 1 | One-clock pulse after each latch load |

## Verification
A strobe edge and a pixel write can fall on the same rising edge. The bench forces this by raising the strobe at the rising edge right after the 160th pixel clock. It pulses the start input at that same edge to begin the next line back to back. The reference model copies its data array before applying the pending write. The latch is compared against the model after every clock, so a design that writes before copying shows the new pixel 159 in the latch and is reported under R9.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    // Fill direction of the data register
    typedef enum logic {
        FILL_DOWN = 1'b0,
        FILL_UP   = 1'b1
    } fill_dir_e;

endpackage

// File: rtl/cpc_edge_capture.sv
// Holds the word seen at the rising edge and the word seen at the falling edge
module cpc_edge_capture #(
    parameter int BUS_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic [BUS_W-1:0] rise_word_o,
    output logic [BUS_W-1:0] fall_word_o
);
    logic [BUS_W-1:0] rise_d, rise_q;
    logic [BUS_W-1:0] fall_d, fall_q;

    always_comb begin
        rise_d = bus_i;
        fall_d = bus_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) rise_q <= '0;
        else          rise_q <= rise_d;
    end

    always_ff @(negedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) fall_q <= '0;
        else          fall_q <= fall_d;
    end

    assign rise_word_o = rise_q;
    assign fall_word_o = fall_q;
endmodule

// File: rtl/cpc_fill_seq.sv
// Arms on a start pulse, counts pixels, passes the start pulse down the chain
module cpc_fill_seq
    import cpc_pkg::*;
#(
    parameter int PIXELS = 160,
    localparam int IDX_W = $clog2(PIXELS)
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             fill_up_i,
    input  logic             start_right_i,
    input  logic             start_left_i,
    output logic             start_right_o,
    output logic             start_left_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PIXELS - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;
    logic casc_d, casc_q;
    logic start_sel;
    fill_dir_e dir;

    always_comb begin
        dir       = fill_dir_e'(fill_up_i);
        start_sel = (dir == FILL_UP) ? start_right_i : start_left_i;
        s_d       = s_q;
        if (start_sel) begin
            s_d.busy = 1'b1;
            s_d.idx  = '0;
        end else if (s_q.busy) begin
            if (s_q.idx == LAST) begin
                s_d.busy = 1'b0;
                s_d.idx  = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
        casc_d = s_q.busy && (s_q.idx == LAST);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) s_q <= '0;
        else          s_q <= s_d;
    end

    // cascade pulse launched on the falling edge of the last pixel clock
    always_ff @(negedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) casc_q <= 1'b0;
        else          casc_q <= casc_d;
    end

    assign start_left_o  = (dir == FILL_UP)   && casc_q;
    assign start_right_o = (dir == FILL_DOWN) && casc_q;
    assign wr_en_o       = s_q.busy;
    assign wr_idx_o      = s_q.idx;

    AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        s_q.busy |-> (s_q.idx <= LAST)); // R4
    AST_CASC_ONE_CLOCK: assert property (@(negedge clk_i) disable iff (!rst_n_i)
        casc_q |=> !casc_q); // R5
    AST_SPARE_PIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(start_left_o && start_right_o)); // R3
endmodule

// File: rtl/cpc_dot_store.sv
// Data register written pixel by pixel, output latch loaded on the strobe edge
module cpc_dot_store
    import cpc_pkg::*;
#(
    parameter int PIXELS = 160,
    parameter int DOTS   = 3,
    parameter int GRAY_W = 8,
    localparam int IDX_W = $clog2(PIXELS),
    localparam int NDOTS = PIXELS * DOTS,
    localparam int PIX_W = DOTS * GRAY_W
) (
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  logic                    fill_up_i,
    input  logic                    invert_i,
    input  logic                    wr_en_i,
    input  logic [IDX_W-1:0]        wr_idx_i,
    input  logic [PIX_W-1:0]        pix_i,
    input  logic                    strobe_i,
    output logic [NDOTS*GRAY_W-1:0] lat_data_o,
    output logic                    lat_valid_o
);
    typedef struct packed {
        logic [NDOTS-1:0][GRAY_W-1:0] dreg;
        logic [NDOTS-1:0][GRAY_W-1:0] lat;
        logic                         stb_prev;
        logic                         valid;
    } store_t;

    store_t st_d, st_q;
    fill_dir_e dir;

    always_comb begin
        dir            = fill_dir_e'(fill_up_i);
        st_d           = st_q;
        st_d.valid     = 1'b0;
        // copy first: a write at this same edge is not part of the latched line
        if (strobe_i && !st_q.stb_prev) begin
            st_d.lat   = st_q.dreg;
            st_d.valid = 1'b1;
        end
        st_d.stb_prev = strobe_i;
        if (wr_en_i) begin
            for (int d = 0; d < DOTS; d++) begin
                automatic int dot  = int'(wr_idx_i) * DOTS + d;
                automatic int slot = (dir == FILL_UP) ? dot : (NDOTS - 1 - dot);
                st_d.dreg[slot] = pix_i[PIX_W-1-d*GRAY_W -: GRAY_W] ^ {GRAY_W{invert_i}};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign lat_data_o  = st_q.lat;
    assign lat_valid_o = st_q.valid;

    AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !lat_valid_o |-> $stable(lat_data_o)); // R6
    AST_VALID_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (strobe_i && !st_q.stb_prev) |=> lat_valid_o); // R6
    AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !wr_en_i |=> $stable(st_q.dreg)); // R4
endmodule

// File: rtl/cascade_pixel_capture.sv
module cascade_pixel_capture #(
    parameter int BUS_W  = 12,
    parameter int GRAY_W = 8,
    parameter int DOTS   = 3,
    parameter int PIXELS = 160,
    localparam int IDX_W = $clog2(PIXELS),
    localparam int PIX_W = 2 * BUS_W,
    localparam int LAT_W = PIXELS * DOTS * GRAY_W
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             fill_up_i,
    input  logic             invert_i,
    input  logic             start_right_i,
    input  logic             start_left_i,
    output logic             start_right_o,
    output logic             start_left_o,
    input  logic [BUS_W-1:0] pix_bus_i,
    input  logic             strobe_i,
    output logic [LAT_W-1:0] lat_data_o,
    output logic             lat_valid_o
);
    logic [BUS_W-1:0] rise_w, fall_w;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    cpc_edge_capture #(.BUS_W(BUS_W)) cap_i (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .bus_i      (pix_bus_i),
        .rise_word_o(rise_w),
        .fall_word_o(fall_w)
    );

    cpc_fill_seq #(.PIXELS(PIXELS)) seq_i (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .fill_up_i    (fill_up_i),
        .start_right_i(start_right_i),
        .start_left_i (start_left_i),
        .start_right_o(start_right_o),
        .start_left_o (start_left_o),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx)
    );

    cpc_dot_store #(.PIXELS(PIXELS), .DOTS(DOTS), .GRAY_W(GRAY_W)) store_i (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .fill_up_i  (fill_up_i),
        .invert_i   (invert_i),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .pix_i      ({rise_w, fall_w}),
        .strobe_i   (strobe_i),
        .lat_data_o (lat_data_o),
        .lat_valid_o(lat_valid_o)
    );
endmodule

// File: tb/cascade_pixel_capture_tb.sv
module cascade_pixel_capture_tb_top;
    localparam int NPIX  = 160;
    localparam int NDOT  = NPIX * 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_up = 1'b1;
    logic        invert = 1'b0;
    logic        st_r_in = 1'b0;
    logic        st_l_in = 1'b0;
    logic        st_r_out, st_l_out;
    logic [11:0] bus = '0;
    logic        strobe = 1'b0;
    logic [NDOT*8-1:0] lat;
    logic        lat_v;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur = "R10";

    // behavioural reference state
    logic [7:0]  m_dreg [NDOT];
    logic [7:0]  m_lat  [NDOT];
    bit          m_busy = 0;
    int          m_idx = 0;
    logic [11:0] m_rise = '0;
    logic [11:0] m_fall = '0;
    bit          m_stbp = 0;
    bit          m_valid = 0;
    bit          m_casc = 0;

    always #5 clk = ~clk;

    cascade_pixel_capture dut_i (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .fill_up_i    (fill_up),
        .invert_i     (invert),
        .start_right_i(st_r_in),
        .start_left_i (st_l_in),
        .start_right_o(st_r_out),
        .start_left_o (st_l_out),
        .pix_bus_i    (bus),
        .strobe_i     (strobe),
        .lat_data_o   (lat),
        .lat_valid_o  (lat_v)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        int bad;
        bad = -1;
        for (int k = 0; k < NDOT; k++)
            if (bad < 0 && lat[k*8 +: 8] !== m_lat[k]) bad = k;
        chk(bad < 0, cur, "latched dot", (bad < 0) ? 0 : longint'(lat[bad*8 +: 8]),
            (bad < 0) ? 0 : longint'(m_lat[bad]));
        chk(lat_v === m_valid, "R6", "lat_valid", longint'(lat_v), longint'(m_valid));
        if (fill_up) begin
            chk(st_l_out === m_casc && st_r_out === 1'b0, "R5",
                "cascade {right,left}", longint'({st_r_out, st_l_out}), longint'({1'b0, m_casc}));
        end else begin
            chk(st_r_out === m_casc && st_l_out === 1'b0, "R3",
                "cascade {right,left}", longint'({st_r_out, st_l_out}), longint'({m_casc, 1'b0}));
        end
    endtask

    // one clock period: rising word, falling word, start pins and strobe
    task automatic tick(input logic [11:0] rw, input logic [11:0] fw,
                        input bit sr, input bit sl, input bit stb);
        logic [23:0] pix;
        bit st;
        bus = rw; st_r_in = sr; st_l_in = sl; strobe = stb;
        @(posedge clk);
        // reference update for this rising edge (copy before write, R9)
        if (stb && !m_stbp) begin
            for (int k = 0; k < NDOT; k++) m_lat[k] = m_dreg[k];
            m_valid = 1;
        end else m_valid = 0;
        m_stbp = stb;
        if (m_busy) begin
            pix = {m_rise, m_fall};
            for (int d = 0; d < 3; d++) begin
                int dot;
                dot = m_idx * 3 + d;
                if (!fill_up) dot = NDOT - 1 - dot;
                m_dreg[dot] = pix[23 - 8*d -: 8] ^ {8{invert}};
            end
        end
        st = fill_up ? sr : sl;
        if (st) begin m_busy = 1; m_idx = 0; end
        else if (m_busy) begin
            if (m_idx == NPIX - 1) begin m_busy = 0; m_idx = 0; end
            else m_idx++;
        end
        m_rise = rw;
        #2;
        bus = fw; st_r_in = 1'b0; st_l_in = 1'b0;
        @(negedge clk);
        m_fall = fw;
        m_casc = m_busy && (m_idx == NPIX - 1);
        #2;
        check_outputs();
    endtask

    function automatic logic [11:0] rword(input int seed, input int i);
        return 12'((seed * 73 + i * 29 + 5) ^ (i << 4));
    endfunction
    function automatic logic [11:0] fword(input int seed, input int i);
        return 12'((seed * 151 + i * 11 + 9) ^ (seed << 7));
    endfunction

    task automatic run_line(input int seed, input int npix, input bit first_start);
        for (int i = 0; i < npix; i++)
            tick(rword(seed, i), fword(seed, i),
                 first_start && i == 0 && fill_up, first_start && i == 0 && !fill_up, 1'b0);
    endtask

    task automatic strobe_seq();
        tick('0, '0, 0, 0, 1'b1);
        tick('0, '0, 0, 0, 1'b1); // held high: no second copy (R6)
        tick('0, '0, 0, 0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int k = 0; k < NDOT; k++) begin m_dreg[k] = '0; m_lat[k] = '0; end
        // R10: reset state
        #23;
        chk(lat === '0, "R10", "latch in reset", longint'(lat[63:0]), 0);
        chk(lat_v === 1'b0, "R10", "lat_valid in reset", longint'(lat_v), 0);
        chk({st_r_out, st_l_out} === 2'b00, "R10", "start outs in reset",
            longint'({st_r_out, st_l_out}), 0);
        @(negedge clk); rst_n = 1'b1; #2;

        // R1/R2: fill upward, start on the right pin
        cur = "R1/R2";
        fill_up = 1'b1; invert = 1'b0;
        run_line(1, NPIX, 1);
        tick('0, '0, 0, 0, 0);
        tick('0, '0, 0, 0, 0);
        cur = "R6";
        strobe_seq();

        // R4: data after the 160th pixel is ignored
        cur = "R4";
        run_line(9, 20, 0);
        strobe_seq();

        // R3: fill downward, start on the left pin, stray pulse on the right pin
        cur = "R3";
        fill_up = 1'b0;
        tick('0, '0, 0, 0, 0);
        for (int i = 0; i < NPIX; i++)
            tick(rword(3, i), fword(3, i), i == 10, i == 0, 1'b0);
        tick('0, '0, 0, 0, 0);
        strobe_seq();

        // R7: inversion while loading
        cur = "R7";
        invert = 1'b1;
        run_line(5, NPIX, 1);
        tick('0, '0, 0, 0, 0);
        strobe_seq();

        // R8: restart in the middle of a line
        cur = "R8";
        fill_up = 1'b1; invert = 1'b0;
        tick('0, '0, 0, 0, 0);
        run_line(6, 50, 1);
        run_line(7, NPIX, 1);
        tick('0, '0, 0, 0, 0);
        strobe_seq();

        // R9: strobe and next start on the edge that stores pixel 159
        cur = "R9";
        run_line(11, NPIX, 1);
        tick(rword(12, 0), fword(12, 0), 1, 0, 1'b1);
        for (int i = 1; i < NPIX; i++)
            tick(rword(12, i), fword(12, i), 0, 0, 1'b0);
        tick('0, '0, 0, 0, 0);
        strobe_seq();

        finish_run();
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule